// File: doc/BRIEF.md
# Parallel Bus Host Transfer Sequencer

This block runs one read or one write at a time on an external asynchronous parallel bus, acting as the host. Configuration inputs give the data width, three wait-state codes, an address stepping mode, a chip-select option for the top address bits and an interrupt mode. Each accepted request passes through three phases, each timed in clock cycles. First comes a setup phase, in which the address and chip select are stable before the strobe. Next comes a strobe phase, in which the read or write strobe is active. Last comes a hold phase, in which the strobe is released but chip select and write data stay valid. When the transfer ends, the block steps the address, drops its busy flag and may pulse an interrupt.

The controller has four states. IDLE waits for a request. SETUP, STROBE and HOLD are the three bus phases. The transitions are:
- IDLE to SETUP on an accepted request.
- SETUP to STROBE when the setup count runs out.
- STROBE to HOLD when the strobe count runs out and the hold length is nonzero.
- STROBE to IDLE when the strobe count runs out and the hold length is zero.
- HOLD to IDLE when the hold count runs out.

Phase lengths and all other settings are captured when the request is accepted. They stay fixed until the transfer ends.

Top module: `pbus_host_seq`

## Requirements
- R1: When `cfg_strobe` is nonzero, the setup phase (busy, chip select active, no strobe) lasts `cfg_setup`+1 cycles.
- R2: The strobe phase (`bus_rd` or `bus_wr` high) lasts `cfg_strobe`+1 cycles.
- R3: When `cfg_strobe` is nonzero, the hold phase after the strobe lasts `cfg_hold`+1 cycles for a write and `cfg_hold` cycles for a read.
- R4: When `cfg_strobe` is 0, `cfg_setup` and `cfg_hold` are ignored. A write then uses a setup of 1 and a hold of 1, and a read uses a setup of 1 and a hold of 0.
- R5: At the end of a transfer, the address changes by `cfg_step`: 00 leaves it, 01 adds one, 10 subtracts one, 11 leaves it. The step is one in both 8-bit and 16-bit mode.
- R6: With `cfg_cs_hi` set, address bits 15:14 keep their value when the address steps, and bits 13:0 wrap within themselves. With `cfg_cs_hi` clear, all 16 bits step.
- R7: With `cfg_wide`=1, all 16 data bits are driven and captured. With `cfg_wide`=0, only bits 7:0 are driven (bits 15:8 of `bus_dout` are 0), and read data is zero-extended from `bus_din[7:0]`.
- R8: Read data is the value of `bus_din` in the last strobe cycle. It shows on `rdata` from the cycle after that, and a write leaves `rdata` unchanged.
- R9: `busy` is 1 from the cycle after an accepted request until the end of the transfer. A request made while busy is ignored.
- R10: With `cfg_irq_mode`=01, `irq` is high for exactly one cycle, the first cycle in which `busy` is 0 again. Modes 00, 10 and 11 give no interrupt.
- R11: `bus_cs` is high in every busy cycle. Only `bus_rd` pulses for a read, and only `bus_wr` for a write. For a write, `bus_doe` is high and `bus_dout` holds the write data from the first setup cycle through the last hold cycle.
- R12: `addr_ld` loads `addr_ld_val` into the address while idle (visible the next cycle). It is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| cfg_setup | input | 2 | Setup wait code |
| cfg_strobe | input | 4 | Strobe wait code |
| cfg_hold | input | 2 | Hold wait code |
| cfg_step | input | 2 | Address stepping mode |
| cfg_irq_mode | input | 2 | Interrupt mode |
| cfg_cs_hi | input | 1 | Address bits 15:14 serve as chip selects |
| addr_ld | input | 1 | Load the address register |
| addr_ld_val | input | 16 | Value to load |
| req | input | 1 | Start a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| wdata | input | 16 | Write data |
| bus_din | input | 16 | Data read from the bus |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle end-of-transfer interrupt |
| bus_cs | output | 1 | Chip select, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Data output enable |
| rdata | output | 16 | Captured read data |

## Verification
The hardest conditions to reach from the ports are a late sample of read data and a request or address load that lands in the middle of a transfer. To expose a late sample, the bench changes `bus_din` in every strobe cycle, so only a capture in the last strobe cycle gives the expected value. To expose mid-transfer effects, the bench raises `req` and `addr_ld` two cycles into a busy transfer. It then checks that no extra transfer appears and that the address after the transfer still follows the stepping rule. The upper-bit lock is reached by loading 0x7FFF and 0x4000 and stepping across the bit-13/bit-14 boundary with `cfg_cs_hi` both set and clear.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } pbus_state_t;

    // Phase lengths in clock cycles
    typedef struct packed {
        logic [2:0] setup_len;   // 1..4
        logic [4:0] strobe_len;  // 1..16
        logic [2:0] hold_len;    // 0..4
    } pbus_timing_t;

    localparam logic [1:0] STEP_INC = 2'b01;
    localparam logic [1:0] STEP_DEC = 2'b10;
    localparam logic [1:0] IRQ_END  = 2'b01;

endpackage

// File: rtl/pbus_wait_calc.sv
module pbus_wait_calc
    import pbus_pkg::*;
(
    input  logic [1:0]   setup_code,
    input  logic [3:0]   strobe_code,
    input  logic [1:0]   hold_code,
    input  logic         is_write,
    output pbus_timing_t timing
);

    logic zero_strobe;

    always_comb begin
        zero_strobe       = (strobe_code == 4'd0);
        timing.strobe_len = 5'(strobe_code) + 5'd1;
        if (zero_strobe) begin
            timing.setup_len = 3'd1;
            timing.hold_len  = is_write ? 3'd1 : 3'd0;
        end else begin
            timing.setup_len = 3'(setup_code) + 3'd1;
            timing.hold_len  = is_write ? (3'(hold_code) + 3'd1) : 3'(hold_code);
        end
    end

endmodule

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/pbus_addr_step.sv
module pbus_addr_step
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CS_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [1:0]        step_mode,
    input  logic              keep_top,
    output logic [ADDR_W-1:0] addr
);

    localparam int LOW_W = ADDR_W - CS_BITS;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        unique case (step_mode)
            STEP_INC: stepped = addr_q + 1'b1;
            STEP_DEC: stepped = addr_q - 1'b1;
            default:  stepped = addr_q;
        endcase
        next_addr = keep_top ? {addr_q[ADDR_W-1:LOW_W], stepped[LOW_W-1:0]} : stepped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step_en) begin
            addr_q <= next_addr;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/pbus_host_seq.sv
module pbus_host_seq
    import pbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int CS_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic [1:0]        cfg_setup,
    input  logic [3:0]        cfg_strobe,
    input  logic [1:0]        cfg_hold,
    input  logic [1:0]        cfg_step,
    input  logic [1:0]        cfg_irq_mode,
    input  logic              cfg_cs_hi,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_ld_val,
    input  logic              req,
    input  logic              req_write,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic              irq,
    output logic              bus_cs,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [DATA_W-1:0] rdata
);

    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = 5;

    pbus_state_t  state_q, state_d;
    pbus_timing_t tim_in, tim_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             accept;
    logic             done;

    logic              dir_wr_q;
    logic              wide_q;
    logic [1:0]        step_q;
    logic [1:0]        irqm_q;
    logic              cshi_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    pbus_wait_calc u_wait (
        .setup_code  (cfg_setup),
        .strobe_code (cfg_strobe),
        .hold_code   (cfg_hold),
        .is_write    (req_write),
        .timing      (tim_in)
    );

    pbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    pbus_addr_step #(.ADDR_W(ADDR_W), .CS_BITS(CS_BITS)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_ld && (state_q == ST_IDLE)),
        .load_val  (addr_ld_val),
        .step_en   (done),
        .step_mode (step_q),
        .keep_top  (cshi_q),
        .addr      (bus_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(tim_in.setup_len) - 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = tim_q.strobe_len - 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    if (tim_q.hold_len == 3'd0) begin
                        state_d = ST_IDLE;
                        done    = 1'b1;
                    end else begin
                        state_d  = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(tim_q.hold_len) - 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_last) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Transfer context, read capture and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tim_q    <= '0;
            dir_wr_q <= 1'b0;
            wide_q   <= 1'b0;
            step_q   <= '0;
            irqm_q   <= '0;
            cshi_q   <= 1'b0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (accept) begin
                tim_q    <= tim_in;
                dir_wr_q <= req_write;
                wide_q   <= cfg_wide;
                step_q   <= cfg_step;
                irqm_q   <= cfg_irq_mode;
                cshi_q   <= cfg_cs_hi;
                wdata_q  <= cfg_wide ? wdata : {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
            end
            if ((state_q == ST_STROBE) && tmr_last && !dir_wr_q) begin
                rdata_q <= wide_q ? bus_din : {{HALF_W{1'b0}}, bus_din[HALF_W-1:0]};
            end
            irq_q <= done && (irqm_q == IRQ_END);
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        bus_cs   = busy;
        bus_rd   = (state_q == ST_STROBE) && !dir_wr_q;
        bus_wr   = (state_q == ST_STROBE) && dir_wr_q;
        bus_doe  = busy && dir_wr_q;
        bus_dout = bus_doe ? wdata_q : '0;
        rdata    = rdata_q;
        irq      = irq_q;
    end

endmodule

// File: rtl/pbus_host_seq_chk.sv
module pbus_host_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              irq,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dout,
    input logic              doe,
    input logic [1:0]        irqm
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr)); // R11
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (rd || wr) |-> cs); // R11
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (doe && $past(doe)) |-> $stable(dout)); // R11
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R10
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (!busy && $past(busy))); // R10
    AST_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irqm == 2'b01)); // R10
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(addr)); // R12

endmodule

bind pbus_host_seq pbus_host_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .irq   (irq),
    .cs    (bus_cs),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .dout  (bus_dout),
    .doe   (bus_doe),
    .irqm  (irqm_q)
);

// File: tb/pbus_host_seq_bench.sv
`timescale 1ns/1ps
module pbus_host_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1;
    logic [1:0]  cfg_setup = '0;
    logic [3:0]  cfg_strobe = '0;
    logic [1:0]  cfg_hold = '0;
    logic [1:0]  cfg_step = '0;
    logic [1:0]  cfg_irq_mode = '0;
    logic        cfg_cs_hi = 1'b0;
    logic        addr_ld = 1'b0;
    logic [15:0] addr_ld_val = '0;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] bus_din = 16'hDEAD;
    logic        busy, irq, bus_cs, bus_rd, bus_wr, bus_doe;
    logic [15:0] bus_addr, bus_dout, rdata;

    always #2.5 clk = ~clk;

    pbus_host_seq u_pbus_host_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_step(cfg_step),
        .cfg_irq_mode(cfg_irq_mode), .cfg_cs_hi(cfg_cs_hi), .addr_ld(addr_ld),
        .addr_ld_val(addr_ld_val), .req(req), .req_write(req_write), .wdata(wdata),
        .bus_din(bus_din), .busy(busy), .irq(irq), .bus_cs(bus_cs), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .rdata(rdata)
    );

    typedef struct {
        int          s;
        int          m;
        int          h;
        logic        wr;
        logic [15:0] dout;
        logic [15:0] rdata;
        logic [15:0] addr;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    logic [15:0] m_addr = '0;
    logic [15:0] m_rdata = '0;
    logic [15:0] din_pat = '0;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Driver: compute expected item, push, issue request
    task automatic xfer(input logic wr, input logic wide, input logic [1:0] sc,
                        input logic [3:0] mc, input logic [1:0] hc, input logic [1:0] st,
                        input logic [1:0] im, input logic cshi, input logic [15:0] wd,
                        input logic [15:0] pat, input bit poke, input string tag);
        exp_t e;
        logic [15:0] v;
        logic [15:0] nx;
        e.m = int'(mc) + 1;
        if (mc == 4'd0) begin
            e.s = 1;
            e.h = wr ? 1 : 0;
        end else begin
            e.s = int'(sc) + 1;
            e.h = wr ? int'(hc) + 1 : int'(hc);
        end
        e.wr   = wr;
        e.dout = wide ? wd : {8'h00, wd[7:0]};
        if (!wr) begin
            v = pat ^ 16'(e.m - 1);
            m_rdata = wide ? v : {8'h00, v[7:0]};
        end
        e.rdata = m_rdata;
        case (st)
            2'b01:   nx = m_addr + 16'd1;
            2'b10:   nx = m_addr - 16'd1;
            default: nx = m_addr;
        endcase
        if (cshi) nx = {m_addr[15:14], nx[13:0]};
        m_addr = nx;
        e.addr = nx;
        e.irq  = (im == 2'b01);
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        din_pat = pat;
        cfg_wide = wide; cfg_setup = sc; cfg_strobe = mc; cfg_hold = hc;
        cfg_step = st; cfg_irq_mode = im; cfg_cs_hi = cshi;
        req_write = wr; wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (poke) begin
            @(negedge clk);
            req = 1'b1; wdata = ~wd; req_write = ~wr;
            addr_ld = 1'b1; addr_ld_val = 16'h5555;
            @(negedge clk);
            req = 1'b0; addr_ld = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_addr(input logic [15:0] a);
        @(negedge clk);
        addr_ld = 1'b1; addr_ld_val = a;
        @(negedge clk);
        addr_ld = 1'b0;
        m_addr = a;
        chk(bus_addr == a, "R12 idle load", 32'(bus_addr), 32'(a));
    endtask

    // Monitor: measure phases and compare against queued items
    int  se = 0, sm = 0, sh = 0, sig_bad = 0;
    bit  seen = 0, prev_busy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (!prev_busy) begin
                    se = 0; sm = 0; sh = 0; sig_bad = 0; seen = 0;
                end
                if (bus_rd || bus_wr) begin
                    if (bus_rd) bus_din = din_pat ^ 16'(sm);
                    sm++;
                    seen = 1;
                end else if (!seen) begin
                    se++;
                end else begin
                    sh++;
                end
                if (!bus_cs) sig_bad++;
                if (q.size() > 0) begin
                    if (q[0].wr) begin
                        if (bus_rd || !bus_doe || bus_dout != q[0].dout) sig_bad++;
                    end else begin
                        if (bus_wr || bus_doe) sig_bad++;
                    end
                end
            end else if (prev_busy) begin
                bus_din = 16'hDEAD;
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected transfer", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(se == e.s, {"R1 R4 setup ", e.tag}, 32'(se), 32'(e.s));
                    chk(sm == e.m, {"R2 strobe ", e.tag}, 32'(sm), 32'(e.m));
                    chk(sh == e.h, {"R3 R4 hold ", e.tag}, 32'(sh), 32'(e.h));
                    chk(sig_bad == 0, {"R11 R7 bus signals ", e.tag}, 32'(sig_bad), 32'd0);
                    chk(rdata == e.rdata, {"R8 R7 rdata ", e.tag}, 32'(rdata), 32'(e.rdata));
                    chk(bus_addr == e.addr, {"R5 R6 addr ", e.tag}, 32'(bus_addr), 32'(e.addr));
                    chk(irq == e.irq, {"R10 irq ", e.tag}, 32'(irq), 32'(e.irq));
                end
            end else if (irq) begin
                chk(0, "R10 stray irq", 32'd1, 32'd0);
            end
            prev_busy = busy;
        end
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !irq && !bus_cs && !bus_rd && !bus_wr && !bus_doe, "R9 reset outputs",
            {26'd0, busy, irq, bus_cs, bus_rd, bus_wr, bus_doe}, 32'd0);
        chk(bus_addr == 16'h0000, "R12 reset addr", 32'(bus_addr), 32'd0);
        rst_n = 1'b1;
        load_addr(16'h1230);
        // R1 R2 R3 R5 R10: wide write, increment, interrupt on
        xfer(1, 1, 2'd1, 4'd2, 2'd2, 2'b01, 2'b01, 0, 16'hA55A, 16'h0000, 0, "wr_w");
        // R3 R8 R5: wide read, decrement, no interrupt
        xfer(0, 1, 2'd3, 4'd4, 2'd3, 2'b10, 2'b00, 0, 16'h0000, 16'hC3A0, 0, "rd_w");
        // R3: read with zero hold, step 11, irq 11 reserved
        xfer(0, 1, 2'd2, 4'd1, 2'd0, 2'b11, 2'b11, 0, 16'h0000, 16'h1F00, 0, "rd_h0");
        // R4: zero strobe override, write and read
        xfer(1, 1, 2'd3, 4'd0, 2'd3, 2'b00, 2'b01, 0, 16'h1234, 16'h0000, 0, "wr_ovr");
        xfer(0, 1, 2'd3, 4'd0, 2'd3, 2'b01, 2'b01, 0, 16'h0000, 16'h7E81, 0, "rd_ovr");
        // R7 R5: 8-bit write and read, step still one; irq mode 10 gives none
        xfer(1, 0, 2'd0, 4'd3, 2'd1, 2'b01, 2'b10, 0, 16'hABCD, 16'h0000, 0, "wr_n");
        xfer(0, 0, 2'd1, 4'd2, 2'd1, 2'b01, 2'b01, 0, 16'h0000, 16'hBEEF, 0, "rd_n");
        // R6: chip-select bits locked across stepping
        load_addr(16'h7FFF);
        xfer(0, 1, 2'd0, 4'd1, 2'd0, 2'b01, 2'b01, 1, 16'h0000, 16'h0101, 0, "cs_inc");
        xfer(0, 1, 2'd0, 4'd1, 2'd0, 2'b01, 2'b01, 0, 16'h0000, 16'h0202, 0, "nocs_inc");
        load_addr(16'h7FFF);
        xfer(1, 1, 2'd0, 4'd1, 2'd0, 2'b01, 2'b00, 0, 16'h0F0F, 16'h0000, 0, "full_inc");
        load_addr(16'h4000);
        xfer(1, 1, 2'd0, 4'd1, 2'd0, 2'b10, 2'b00, 1, 16'hF0F0, 16'h0000, 0, "cs_dec");
        // R9 R12: request and address load while busy are ignored
        xfer(1, 1, 2'd3, 4'd5, 2'd2, 2'b01, 2'b01, 0, 16'h6789, 16'h0000, 1, "poke_wr");
        xfer(0, 1, 2'd1, 4'd15, 2'd2, 2'b10, 2'b01, 0, 16'h0000, 16'h9000, 1, "poke_rd");
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R9 all transfers seen", 32'(q.size()), 32'd0);
        chk(!busy, "R9 idle at end", 32'(busy), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule